// File: doc/BRIEF.md
# 8B/10B Code-Group Encoder with Per-Word Disparity Override

This block turns one byte per clock into a ten-bit DC-balanced code group. A control flag picks between the data alphabet and the small set of special control groups. The block tracks running disparity across words. Normally, that running disparity decides which of the two forms of an unbalanced group is sent.

A per-word force input takes that choice away from the running state. A companion select input then names the column the group is taken from. After a forced word, the running disparity continues from whatever the emitted group actually left. This keeps the following unforced words legal. A control request for a byte outside the twelve legal control groups is flagged, and that byte is sent as data.

The output is registered. Each accepted word produces its code group one clock later, qualified by an output valid.

Top module: `cg_encoder`

## Requirements
- R1: While reset is high and afterwards until the first accepted word, `out_vld`, `out_code` and `out_ctl_err` are all zero, and the running disparity starts negative, so the first unforced byte 0xBC with `in_ctl` high yields 10'b0011111010.
- R2: With `in_ctl` low, the byte is sent as a data group. Its low five bits (EDCBA) map to the six-bit subblock in `out_code[9:4]`, with bit a at `out_code[9]`. Its high three bits (HGF) map to the four-bit subblock in `out_code[3:0]`, with bit f at `out_code[3]`. Byte 0x00 at negative disparity gives 10'b1001110100, and byte 0xB5 gives 10'b1010101010 in either state. The 256 data bytes give 256 distinct groups for a given starting disparity.
- R3: With `in_ctl` high and a legal control byte, the control alphabet is used. At negative disparity, 0xBC gives 10'b0011111010 and 0xF7 gives 10'b1110101000. At positive disparity, 0xBC gives 10'b1100000101.
- R4: Every valid group has 4, 5 or 6 ones. When the starting disparity is negative it has 5 or 6 ones, and when positive it has 4 or 5. The running state becomes positive after 6 ones, negative after 4, and is unchanged after 5.
- R5: Where a plain D.x.7 ending would make five equal bits run into the next subblock, the alternate ending is used. At negative disparity, 0xF1 gives 10'b1000110111. At positive disparity, 0xEB gives 10'b1101001000. In an unforced stream, no more than five equal bits ever run in a row.
- R6: With `in_force` high and `in_dval` high, the group is taken from the negative-disparity column (the form sent when running disparity is negative), whatever the running state.
- R7: With `in_force` high and `in_dval` low, the group is taken from the positive-disparity column, whatever the running state.
- R8: After a forced word, the running disparity is the forced starting disparity advanced through the emitted group. The next unforced word encodes from that state.
- R9: A control request for any byte other than the twelve legal control bytes (low five bits equal to 28, or byte 0xF7, 0xFB, 0xFD or 0xFE) raises `out_ctl_err` alongside that word's group. The group carries the data encoding of the byte. Legal control bytes and all data words leave the flag low.
- R10: `out_vld` follows `in_vld` one clock later. While `in_vld` is low, `out_code` holds its last value and the running disparity does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word strobe |
| in_byte | input | 8 | Byte to encode |
| in_ctl | input | 1 | High for control alphabet, low for data |
| in_force | input | 1 | High to override running disparity for this word |
| in_dval | input | 1 | Column choice when forced: high negative, low positive |
| out_vld | output | 1 | Code group valid |
| out_code | output | 10 | Code group, first transmitted bit at index 9 |
| out_ctl_err | output | 1 | Illegal control request for this group |

## Verification
The disparity override and the illegal-control fallback can act on the same word. The override picks the column while the fallback swaps the alphabet, and the running-state update must then follow the data group actually sent. The bench provokes this by sending byte 0x00 as a control request forced to the positive column. It expects 10'b0110001011 with the error flag raised. It then sends the same byte unforced as data and expects the identical group, which shows the state was left positive by the neutral fallback group.

// File: rtl/cg_enc_pkg.sv
package cg_enc_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 10;
    localparam int SUB6_W = 6;
    localparam int SUB4_W = 4;
    localparam int X_W    = 5;
    localparam int Y_W    = 3;

    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_e;

    typedef struct packed {
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
    } byte_split_t;

    // Six-bit subblock (abcdei, a at bit 5) for the negative-disparity column.
    function automatic logic [SUB6_W-1:0] six_neg(input logic [X_W-1:0] x);
        logic [SUB6_W-1:0] r;
        case (x)
            5'd0:  r = 6'b100111;
            5'd1:  r = 6'b011101;
            5'd2:  r = 6'b101101;
            5'd3:  r = 6'b110001;
            5'd4:  r = 6'b110101;
            5'd5:  r = 6'b101001;
            5'd6:  r = 6'b011001;
            5'd7:  r = 6'b111000;
            5'd8:  r = 6'b111001;
            5'd9:  r = 6'b100101;
            5'd10: r = 6'b010101;
            5'd11: r = 6'b110100;
            5'd12: r = 6'b001101;
            5'd13: r = 6'b101100;
            5'd14: r = 6'b011100;
            5'd15: r = 6'b010111;
            5'd16: r = 6'b011011;
            5'd17: r = 6'b100011;
            5'd18: r = 6'b010011;
            5'd19: r = 6'b110010;
            5'd20: r = 6'b001011;
            5'd21: r = 6'b101010;
            5'd22: r = 6'b011010;
            5'd23: r = 6'b111010;
            5'd24: r = 6'b110011;
            5'd25: r = 6'b100110;
            5'd26: r = 6'b010110;
            5'd27: r = 6'b110110;
            5'd28: r = 6'b001110;
            5'd29: r = 6'b101110;
            5'd30: r = 6'b011110;
            default: r = 6'b101011;
        endcase
        return r;
    endfunction

    // Four-bit data subblock (fghj, f at bit 3), negative column.
    function automatic logic [SUB4_W-1:0] four_data_neg(input logic [Y_W-1:0] y,
                                                        input logic alt);
        logic [SUB4_W-1:0] r;
        case (y)
            3'd0: r = 4'b1011;
            3'd1: r = 4'b1001;
            3'd2: r = 4'b0101;
            3'd3: r = 4'b1100;
            3'd4: r = 4'b1101;
            3'd5: r = 4'b1010;
            3'd6: r = 4'b0110;
            default: r = alt ? 4'b0111 : 4'b1110;
        endcase
        return r;
    endfunction

    // Four-bit control subblock, selected when the six-bit stage left
    // the running disparity negative; the positive case is its complement.
    function automatic logic [SUB4_W-1:0] four_ctl_neg(input logic [Y_W-1:0] y);
        logic [SUB4_W-1:0] r;
        case (y)
            3'd0: r = 4'b1011;
            3'd1: r = 4'b0110;
            3'd2: r = 4'b1010;
            3'd3: r = 4'b1100;
            3'd4: r = 4'b1101;
            3'd5: r = 4'b0101;
            3'd6: r = 4'b1001;
            default: r = 4'b0111;
        endcase
        return r;
    endfunction

    function automatic rd_e rd_step6(input rd_e rd_in, input logic [SUB6_W-1:0] b);
        int ones;
        ones = $countones(b);
        if (ones == SUB6_W / 2) return rd_in;
        return (ones > SUB6_W / 2) ? RD_POS : RD_NEG;
    endfunction

    function automatic rd_e rd_step4(input rd_e rd_in, input logic [SUB4_W-1:0] b);
        int ones;
        ones = $countones(b);
        if (ones == SUB4_W / 2) return rd_in;
        return (ones > SUB4_W / 2) ? RD_POS : RD_NEG;
    endfunction

endpackage

// File: rtl/cg_ctl_check.sv
module cg_ctl_check
    import cg_enc_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              legal_o,
    output logic              is_k28_o
);
    byte_split_t sp;
    logic        x7_ok;

    always_comb begin
        sp       = '{x: byte_i[X_W-1:0], y: byte_i[BYTE_W-1:X_W]};
        is_k28_o = (sp.x == 5'd28);
        x7_ok    = (sp.y == 3'd7) &&
                   ((sp.x == 5'd23) || (sp.x == 5'd27) ||
                    (sp.x == 5'd29) || (sp.x == 5'd30));
        legal_o  = is_k28_o || x7_ok;
    end
endmodule

// File: rtl/cg_sub6.sv
module cg_sub6
    import cg_enc_pkg::*;
(
    input  logic [X_W-1:0]    x_i,
    input  logic              k28_i,
    input  rd_e               rd_i,
    output logic [SUB6_W-1:0] bits_o,
    output rd_e               rd_o
);
    logic [SUB6_W-1:0] base;
    logic              swap;

    always_comb begin
        base   = k28_i ? 6'b001111 : six_neg(x_i);
        swap   = ($countones(base) != SUB6_W / 2) || (!k28_i && x_i == 5'd7);
        bits_o = (rd_i == RD_POS && swap) ? ~base : base;
        rd_o   = rd_step6(rd_i, bits_o);
    end
endmodule

// File: rtl/cg_sub4.sv
module cg_sub4
    import cg_enc_pkg::*;
(
    input  logic [Y_W-1:0]    y_i,
    input  logic [X_W-1:0]    x_i,
    input  logic              ctl_i,
    input  rd_e               rd_i,
    output logic [SUB4_W-1:0] bits_o,
    output rd_e               rd_o
);
    logic [SUB4_W-1:0] base;
    logic              swap;
    logic              alt;

    always_comb begin
        alt = (y_i == 3'd7) &&
              ((rd_i == RD_NEG && (x_i == 5'd17 || x_i == 5'd18 || x_i == 5'd20)) ||
               (rd_i == RD_POS && (x_i == 5'd11 || x_i == 5'd13 || x_i == 5'd14)));
        if (ctl_i) begin
            base = four_ctl_neg(y_i);
            swap = 1'b1;
        end else begin
            base = four_data_neg(y_i, alt);
            swap = (y_i == 3'd0) || (y_i == 3'd3) || (y_i == 3'd4) || (y_i == 3'd7);
        end
        bits_o = (rd_i == RD_POS && swap) ? ~base : base;
        rd_o   = rd_step4(rd_i, bits_o);
    end
endmodule

// File: rtl/cg_encoder.sv
module cg_encoder
    import cg_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_ctl,
    input  logic              in_force,
    input  logic              in_dval,
    output logic              out_vld,
    output logic [CODE_W-1:0] out_code,
    output logic              out_ctl_err
);
    rd_e               rd_q;
    rd_e               rd_start;
    rd_e               rd_mid;
    rd_e               rd_end;
    logic              legal;
    logic              is_k28;
    logic              ctl_eff;
    logic [SUB6_W-1:0] b6;
    logic [SUB4_W-1:0] b4;

    assign rd_start = in_force ? (in_dval ? RD_NEG : RD_POS) : rd_q;
    assign ctl_eff  = in_ctl && legal;

    cg_ctl_check u_ctl (
        .byte_i   (in_byte),
        .legal_o  (legal),
        .is_k28_o (is_k28)
    );

    cg_sub6 u_s6 (
        .x_i    (in_byte[X_W-1:0]),
        .k28_i  (ctl_eff && is_k28),
        .rd_i   (rd_start),
        .bits_o (b6),
        .rd_o   (rd_mid)
    );

    cg_sub4 u_s4 (
        .y_i    (in_byte[BYTE_W-1:X_W]),
        .x_i    (in_byte[X_W-1:0]),
        .ctl_i  (ctl_eff),
        .rd_i   (rd_mid),
        .bits_o (b4),
        .rd_o   (rd_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q        <= RD_NEG;
            out_vld     <= 1'b0;
            out_code    <= '0;
            out_ctl_err <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_code    <= {b6, b4};
                out_ctl_err <= in_ctl && !legal;
                rd_q        <= rd_end;
            end else begin
                out_ctl_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cg_encoder_chk.sv
module cg_encoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_vld,
    input logic       in_force,
    input logic       in_dval,
    input logic       out_vld,
    input logic [9:0] out_code,
    input logic       out_ctl_err,
    input logic       rd_state
);
    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(out_code) && $stable(rd_state)));

    assert_ones_range_R4: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($countones(out_code) >= 4 && $countones(out_code) <= 6));

    assert_rd_heavy_R4: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $countones(out_code) == 6) |-> rd_state);

    assert_rd_light_R4: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $countones(out_code) == 4) |-> !rd_state);

    assert_rd_neutral_R8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_force) |=>
            (($countones(out_code) == 5) -> (rd_state == $past(rd_state))));

    assert_force_neg_R6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_force && in_dval) |=> ($countones(out_code) >= 5));

    assert_force_pos_R7: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_force && !in_dval) |=> ($countones(out_code) <= 5));

    assert_err_qualified_R9: assert property (@(posedge clk) disable iff (rst)
        out_ctl_err |-> out_vld);
endmodule

bind cg_encoder cg_encoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_vld      (in_vld),
    .in_force    (in_force),
    .in_dval     (in_dval),
    .out_vld     (out_vld),
    .out_code    (out_code),
    .out_ctl_err (out_ctl_err),
    .rd_state    (rd_q)
);

// File: tb/cg_encoder_tb.sv
module cg_encoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ctl = 1'b0;
    logic       in_force = 1'b0;
    logic       in_dval = 1'b0;
    logic       out_vld;
    logic [9:0] out_code;
    logic       out_ctl_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cg_encoder u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte),
        .in_ctl(in_ctl), .in_force(in_force), .in_dval(in_dval),
        .out_vld(out_vld), .out_code(out_code), .out_ctl_err(out_ctl_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drives one word for one cycle; returns with the registered result visible.
    task automatic put(input logic [7:0] b, input logic c, input logic f, input logic v);
        @(negedge clk);
        in_vld = 1'b1; in_byte = b; in_ctl = c; in_force = f; in_dval = v;
        @(negedge clk);
        in_vld = 1'b0; in_force = 1'b0; in_ctl = 1'b0;
    endtask

    function automatic bit legal_ctl(input logic [7:0] b);
        return (b[4:0] == 5'd28) || (b == 8'hF7) || (b == 8'hFB) ||
               (b == 8'hFD) || (b == 8'hFE);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 vld in reset", out_vld, 0);
        check("R1 code in reset", out_code, 0);
        check("R1 err in reset", out_ctl_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vld idle after reset", out_vld, 0);
        put(8'hBC, 1, 0, 0);
        check("R1 first group negative", out_code, 10'b0011111010);
    endtask

    task automatic t_known();
        do_reset();
        put(8'h00, 0, 0, 0);
        check("R2 D0.0 neg", out_code, 10'b1001110100);
        check("R10 vld after word", out_vld, 1);
        put(8'hB5, 0, 0, 0);
        check("R2 D21.5", out_code, 10'b1010101010);
        do_reset();
        put(8'hBC, 1, 0, 0);
        check("R3 K28.5 neg", out_code, 10'b0011111010);
        check("R9 legal K no err", out_ctl_err, 0);
        put(8'hBC, 1, 0, 0);
        check("R3 K28.5 pos", out_code, 10'b1100000101);
        do_reset();
        put(8'hF7, 1, 0, 0);
        check("R3 K23.7 neg", out_code, 10'b1110101000);
    endtask

    task automatic t_alt7();
        do_reset();
        put(8'hF1, 0, 0, 0);
        check("R5 D17.7 neg alternate", out_code, 10'b1000110111);
        do_reset();
        put(8'hBC, 1, 0, 0);
        put(8'hEB, 0, 0, 0);
        check("R5 D11.7 pos alternate", out_code, 10'b1101001000);
    endtask

    task automatic t_force();
        do_reset();
        put(8'hBC, 1, 1, 1);
        check("R6 forced neg col", out_code, 10'b0011111010);
        put(8'hBC, 1, 1, 1);
        check("R6 forced neg again", out_code, 10'b0011111010);
        do_reset();
        put(8'hBC, 1, 1, 0);
        check("R7 forced pos col from neg state", out_code, 10'b1100000101);
        put(8'hBC, 1, 0, 0);
        check("R8 state after forced pos group", out_code, 10'b0011111010);
        do_reset();
        put(8'hBC, 1, 0, 0);
        put(8'hBC, 1, 1, 1);
        check("R6 forced neg col from pos state", out_code, 10'b0011111010);
        put(8'hBC, 1, 0, 0);
        check("R8 state after forced neg group", out_code, 10'b1100000101);
    endtask

    task automatic t_bad_ctl();
        do_reset();
        put(8'h00, 1, 0, 0);
        check("R9 bad K err", out_ctl_err, 1);
        check("R9 bad K data code", out_code, 10'b1001110100);
        put(8'h00, 0, 0, 0);
        check("R9 err clears on data", out_ctl_err, 0);
        // Override and fallback in the same word.
        do_reset();
        put(8'h00, 1, 1, 0);
        check("R9 forced bad K err", out_ctl_err, 1);
        check("R7 forced bad K pos col", out_code, 10'b0110001011);
        put(8'h00, 0, 0, 0);
        check("R8 neutral fallback keeps pos", out_code, 10'b0110001011);
    endtask

    task automatic t_ctl_sweep();
        int n_err;
        n_err = 0;
        do_reset();
        for (int i = 0; i < 256; i++) begin
            put(8'(i), 1, 0, 0);
            if (out_ctl_err) n_err++;
            check("R9 err vs legality", out_ctl_err, legal_ctl(8'(i)) ? 0 : 1);
        end
        check("R9 illegal control count", n_err, 244);
    endtask

    task automatic t_hold();
        logic [9:0] last;
        do_reset();
        put(8'hBC, 1, 0, 0);
        last = out_code;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 vld low when idle", out_vld, 0);
            check("R10 code held", out_code, last);
        end
        put(8'hBC, 1, 0, 0);
        check("R10 state kept over idle", out_code, 10'b1100000101);
    endtask

    task automatic t_stream();
        bit seen [2][1024];
        bit rd;
        bit prev;
        int run;
        int ones;
        do_reset();
        rd = 1'b0;
        run = 0;
        prev = 1'b0;
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 1024; c++) seen[r][c] = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 256; i++) begin
                put(8'((i * 37 + pass * 11) % 256), 0, 0, 0);
                ones = $countones(out_code);
                if (rd) check("R4 pos start ones", (ones == 4 || ones == 5) ? 1 : 0, 1);
                else    check("R4 neg start ones", (ones == 5 || ones == 6) ? 1 : 0, 1);
                if (pass == 0) begin
                    check("R2 distinct per state", seen[rd][out_code], 0);
                    seen[rd][out_code] = 1'b1;
                end
                for (int b = 9; b >= 0; b--) begin
                    if (run > 0 && out_code[b] == prev) run++;
                    else run = 1;
                    prev = out_code[b];
                    if (run > 5) begin
                        check("R5 run length", run, 5);
                        run = 0;
                    end
                end
                if (ones == 6) rd = 1'b1;
                else if (ones == 4) rd = 1'b0;
            end
        end
    endtask

    initial begin
        t_reset();
        t_known();
        t_alt7();
        t_force();
        t_bad_ctl();
        t_hold();
        t_ctl_sweep();
        t_stream();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule